// File: doc/BRIEF.md
# Two-Port Byte Store with Collision Arbitration

This block is a clocked model of a byte-wide memory that two masters, called left and right, reach through two fully separate ports. Each port has its own select, direction, output-enable and semaphore-select pins, its own address and its own data paths. Both ports can work in the same cycle on any locations. Writes land on the clock edge. Read data comes back one cycle later, together with a drive-enable that tells the pad logic when to put the byte on the bus. The array holds 2**ADDR_W bytes. ADDR_W = 15 gives the 32768-byte organisation. The default is smaller so that a default elaboration stays light.

When both ports select the same address in one cycle, an on-block arbiter picks a winner and raises a busy flag to the loser in that same cycle. A busy port has its write dropped, so a collision never corrupts the cell. The left port wins a fresh collision. A port that was already on the address in the previous cycle keeps it for as long as it stays there. A strap input chooses between two roles. As master, the local arbiter makes busy and drives it out. As slave, busy comes in from outside and the local busy outputs stay low. Several blocks can then share one arbiter to build a wider word.

Top module: `dpsr_top`

## Requirements
- R1: Each port reaches every one of the 2**ADDR_W byte locations, including address 0 and the top address, through an ADDR_W-bit address and a DATA_W-bit data bus (default DATA_W = 8).
- R2: While a port's active-low select (ce_n) is high, the port does no memory access: a write there leaves the cell unchanged, and the port's drive-enable is low in the following cycle.
- R3: With ce_n low, sem_n high and rd_wr_n low, the port's input byte is stored at its address on the clock edge, unless the port is busy.
- R4: With ce_n low, sem_n high, rd_wr_n high and oe_n low, the port's dout shows the addressed byte in the following cycle and its dout_en is high in that cycle.
- R5: While oe_n is high, dout_en is low in the following cycle and dout reads zero, whatever the other pins are.
- R6: While sem_n is low, the port does no memory access: a write is ignored and dout_en stays low.
- R7: The two ports work independently. Writes to two different addresses in one cycle both take effect, and reads of two different addresses in one cycle both return correct data.
- R8: In master mode (ms_master = 1), if both ports are active on the same address in one cycle and neither was active on that address in the previous cycle, r_busy_o goes high and l_busy_o stays low in that same cycle.
- R9: In master mode, a port that was active on an address in the previous cycle and is still on it keeps priority over the other port arriving there: the newcomer sees busy. While both stay on the address, the previous winner keeps winning.
- R10: A write from a busy port is suppressed and the cell keeps its old value.
- R11: In slave mode (ms_master = 0), both busy outputs are low, and write suppression follows the l_busy_i and r_busy_i inputs rather than the local arbiter.
- R12: The busy outputs are always driven to a known level, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_master | input | 1 | Role strap: 1 = local arbiter makes busy, 0 = busy comes from the inputs |
| l_ce_n | input | 1 | Left select, active low |
| l_rd_wr_n | input | 1 | Left direction: 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore select, active low (low disables memory access) |
| l_addr | input | ADDR_W | Left byte address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data, valid one cycle after the request |
| l_dout_en | output | 1 | Left drive-enable for the data pads |
| l_busy_o | output | 1 | Left busy in master mode, low in slave mode |
| l_busy_i | input | 1 | Left busy from outside, used in slave mode |
| r_ce_n | input | 1 | Right select, active low |
| r_rd_wr_n | input | 1 | Right direction: 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low (low disables memory access) |
| r_addr | input | ADDR_W | Right byte address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data, valid one cycle after the request |
| r_dout_en | output | 1 | Right drive-enable for the data pads |
| r_busy_o | output | 1 | Right busy in master mode, low in slave mode |
| r_busy_i | input | 1 | Right busy from outside, used in slave mode |

## Verification
Each port runs writes and reads at opposite ends of the address range in the same cycle. This separates true independence from address aliasing or a shared data path. Requests with select high, output enable high or semaphore select low are each followed by a read-back, which shows whether the gated access left a trace. Same-address patterns cover three cases: both ports arriving together, the right port already holding the address when the left one arrives, and both ports staying on the address for a second cycle. These tell the fixed left preference apart from incumbent priority and from the previous winner being kept. Each collision ends in a read-back that shows the blocked write was dropped. A final run in slave mode drives the external busy inputs against port traffic, which confirms that the local arbiter is bypassed.

// File: rtl/dpsr_pkg.sv
package dpsr_pkg;

    parameter int DPSR_ADDR_W = 11;
    parameter int DPSR_DATA_W = 8;
    parameter int DPSR_NPORT  = 2;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // decoded intent of one port for the current cycle
    typedef struct packed {
        logic active;    // memory cycle requested
        logic wr;        // store request
        logic rd_drive;  // read with pads enabled
    } port_op_t;

    function automatic port_op_t decode_pins(
        input logic ce_n,
        input logic rd_wr_n,
        input logic oe_n,
        input logic sem_n
    );
        port_op_t o;
        o.active   = !ce_n && sem_n;
        o.wr       = o.active && !rd_wr_n;
        o.rd_drive = o.active && rd_wr_n && !oe_n;
        return o;
    endfunction

    function automatic logic same_cell(
        input logic act_a,
        input logic act_b,
        input logic [31:0] addr_a,
        input logic [31:0] addr_b
    );
        return act_a && act_b && (addr_a == addr_b);
    endfunction

endpackage

// File: rtl/dpsr_port.sv
module dpsr_port
    import dpsr_pkg::*;
#(
    parameter int DATA_W = DPSR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              rd_wr_n,
    input  logic              oe_n,
    input  logic              sem_n,
    input  logic [DATA_W-1:0] rdata,
    output port_op_t          op,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic drive_q;

    always_comb begin
        op = decode_pins(ce_n, rd_wr_n, oe_n, sem_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= op.rd_drive;
        end
    end

    assign dout_en = drive_q;
    assign dout    = drive_q ? rdata : '0;

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && sem_n && rd_wr_n && !oe_n) |=> dout_en);

    assert_oe_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (!dout_en && dout == '0));

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || !sem_n) |=> !dout_en);

endmodule

// File: rtl/dpsr_array.sv
module dpsr_array
    import dpsr_pkg::*;
#(
    parameter int ADDR_W = DPSR_ADDR_W,
    parameter int DATA_W = DPSR_DATA_W,
    parameter int NPORT  = DPSR_NPORT
) (
    input  logic              clk,
    input  logic [NPORT-1:0]  we,
    input  logic [ADDR_W-1:0] addr  [NPORT],
    input  logic [DATA_W-1:0] wdata [NPORT],
    output logic [DATA_W-1:0] rdata [NPORT]
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // lower-numbered port is applied last, so it prevails if two stores meet
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (we[p]) begin
                cells[addr[p]] <= wdata[p];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_rd
            always_ff @(posedge clk) begin
                rdata[g] <= cells[addr[g]];
            end
        end
    endgenerate

endmodule

// File: rtl/dpsr_arbiter.sv
module dpsr_arbiter
    import dpsr_pkg::*;
#(
    parameter int ADDR_W = DPSR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_master,
    input  logic              l_act,
    input  logic              r_act,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_i,
    input  logic              r_busy_i,
    output logic              l_block,
    output logic              r_block,
    output logic              l_busy_o,
    output logic              r_busy_o
);

    logic              pl_act, pr_act;
    logic [ADDR_W-1:0] pl_addr, pr_addr;
    side_e             last_win;

    logic  collide, l_held, r_held;
    side_e winner;
    logic  arb_l, arb_r;

    always_comb begin
        collide = (l_act && r_act) && (l_addr == r_addr);
        l_held  = pl_act && (pl_addr == l_addr);
        r_held  = pr_act && (pr_addr == r_addr);
        if (l_held && r_held) begin
            winner = last_win;
        end else if (r_held) begin
            winner = SIDE_RIGHT;
        end else begin
            winner = SIDE_LEFT;
        end
        arb_l = collide && (winner == SIDE_RIGHT);
        arb_r = collide && (winner == SIDE_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pl_act   <= 1'b0;
            pr_act   <= 1'b0;
            pl_addr  <= '0;
            pr_addr  <= '0;
            last_win <= SIDE_LEFT;
        end else begin
            pl_act   <= l_act;
            pr_act   <= r_act;
            pl_addr  <= l_addr;
            pr_addr  <= r_addr;
            last_win <= (collide && winner == SIDE_RIGHT) ? SIDE_RIGHT : SIDE_LEFT;
        end
    end

    assign l_busy_o = ms_master & arb_l;
    assign r_busy_o = ms_master & arb_r;
    assign l_block  = ms_master ? arb_l : l_busy_i;
    assign r_block  = ms_master ? arb_r : r_busy_i;

    assert_single_loser_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l_busy_o, r_busy_o}));

    assert_busy_known_R12: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({l_busy_o, r_busy_o}));

    assert_fresh_left_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (ms_master && same_cell(l_act, r_act, 32'(l_addr), 32'(r_addr))
         && !(pl_act && pl_addr == l_addr) && !(pr_act && pr_addr == r_addr))
        |-> (r_busy_o && !l_busy_o));

    assert_owner_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (ms_master && same_cell(l_act, r_act, 32'(l_addr), 32'(r_addr))
         && (pr_act && pr_addr == r_addr) && !(pl_act && pl_addr == l_addr))
        |-> (l_busy_o && !r_busy_o));

    assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !ms_master |-> (!l_busy_o && !r_busy_o));

endmodule

// File: rtl/dpsr_top.sv
module dpsr_top
    import dpsr_pkg::*;
#(
    parameter int ADDR_W = DPSR_ADDR_W,
    parameter int DATA_W = DPSR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_master,
    input  logic              l_ce_n,
    input  logic              l_rd_wr_n,
    input  logic              l_oe_n,
    input  logic              l_sem_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_dout_en,
    output logic              l_busy_o,
    input  logic              l_busy_i,
    input  logic              r_ce_n,
    input  logic              r_rd_wr_n,
    input  logic              r_oe_n,
    input  logic              r_sem_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_dout_en,
    output logic              r_busy_o,
    input  logic              r_busy_i
);

    localparam int NP = DPSR_NPORT;

    logic [NP-1:0]     ce_n_v, rw_v, oe_v, sem_v, block_v, we_v;
    logic [ADDR_W-1:0] addr_v  [NP];
    logic [DATA_W-1:0] wdat_v  [NP];
    logic [DATA_W-1:0] rdat_v  [NP];
    logic [DATA_W-1:0] dout_v  [NP];
    logic [NP-1:0]     den_v;
    port_op_t          op_v    [NP];

    assign ce_n_v = {r_ce_n, l_ce_n};
    assign rw_v   = {r_rd_wr_n, l_rd_wr_n};
    assign oe_v   = {r_oe_n, l_oe_n};
    assign sem_v  = {r_sem_n, l_sem_n};
    assign addr_v[SIDE_LEFT]  = l_addr;
    assign addr_v[SIDE_RIGHT] = r_addr;
    assign wdat_v[SIDE_LEFT]  = l_din;
    assign wdat_v[SIDE_RIGHT] = r_din;

    genvar g;
    generate
        for (g = 0; g < NP; g++) begin : g_port
            dpsr_port #(.DATA_W(DATA_W)) u_port (
                .clk     (clk),
                .rst     (rst),
                .ce_n    (ce_n_v[g]),
                .rd_wr_n (rw_v[g]),
                .oe_n    (oe_v[g]),
                .sem_n   (sem_v[g]),
                .rdata   (rdat_v[g]),
                .op      (op_v[g]),
                .dout    (dout_v[g]),
                .dout_en (den_v[g])
            );
            assign we_v[g] = op_v[g].wr && !block_v[g];
        end
    endgenerate

    dpsr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .ms_master (ms_master),
        .l_act     (op_v[SIDE_LEFT].active),
        .r_act     (op_v[SIDE_RIGHT].active),
        .l_addr    (l_addr),
        .r_addr    (r_addr),
        .l_busy_i  (l_busy_i),
        .r_busy_i  (r_busy_i),
        .l_block   (block_v[SIDE_LEFT]),
        .r_block   (block_v[SIDE_RIGHT]),
        .l_busy_o  (l_busy_o),
        .r_busy_o  (r_busy_o)
    );

    dpsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NP)) u_mem (
        .clk   (clk),
        .we    (we_v),
        .addr  (addr_v),
        .wdata (wdat_v),
        .rdata (rdat_v)
    );

    assign l_dout    = dout_v[SIDE_LEFT];
    assign r_dout    = dout_v[SIDE_RIGHT];
    assign l_dout_en = den_v[SIDE_LEFT];
    assign r_dout_en = den_v[SIDE_RIGHT];

    assert_busy_store_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (ms_master && l_busy_o) |-> !we_v[SIDE_LEFT]);

    assert_slave_follows_input_R11: assert property (@(posedge clk) disable iff (rst)
        (!ms_master && r_busy_i) |-> !we_v[SIDE_RIGHT]);

endmodule

// File: tb/sim_dpsr_top.sv
module sim_dpsr_top;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int TOP = (1 << AW) - 1;

    typedef struct {
        bit            ce_n;
        bit            rdwr_n;
        bit            oe_n;
        bit            sem_n;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } drv_t;

    typedef struct {
        bit            en;
        bit            care;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_master = 1'b1;
    logic l_ce_n = 1, l_rd_wr_n = 1, l_oe_n = 1, l_sem_n = 1, l_busy_i = 0;
    logic r_ce_n = 1, r_rd_wr_n = 1, r_oe_n = 1, r_sem_n = 1, r_busy_i = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_din = '0, r_din = '0;
    logic [DW-1:0] l_dout, r_dout;
    logic l_dout_en, r_dout_en, l_busy_o, r_busy_o;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 0;
    logic [DW-1:0] model [1 << AW];
    exp_t q_l[$];
    exp_t q_r[$];

    always #2 clk = ~clk;

    dpsr_top u0 (
        .clk(clk), .rst(rst), .ms_master(ms_master),
        .l_ce_n(l_ce_n), .l_rd_wr_n(l_rd_wr_n), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
        .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_dout_en(l_dout_en),
        .l_busy_o(l_busy_o), .l_busy_i(l_busy_i),
        .r_ce_n(r_ce_n), .r_rd_wr_n(r_rd_wr_n), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
        .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_dout_en(r_dout_en),
        .r_busy_o(r_busy_o), .r_busy_i(r_busy_i)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic drv_t idle();
        drv_t v = '{1, 1, 1, 1, '0, '0};
        return v;
    endfunction
    function automatic drv_t wr(input int a, input int d);
        drv_t v = '{0, 0, 1, 1, AW'(a), DW'(d)};
        return v;
    endfunction
    function automatic drv_t rd(input int a);
        drv_t v = '{0, 1, 0, 1, AW'(a), '0};
        return v;
    endfunction

    // one cycle of stimulus; eb_* are the expected busy outputs
    task automatic step(input drv_t l, input drv_t r, input bit eb_l, input bit eb_r,
                        input bit bi_l, input bit bi_r, input string tag);
        exp_t el, er;
        bit   act_l, act_r, blk_l, blk_r;
        @(negedge clk);
        l_ce_n = l.ce_n; l_rd_wr_n = l.rdwr_n; l_oe_n = l.oe_n; l_sem_n = l.sem_n;
        l_addr = l.a; l_din = l.d; l_busy_i = bi_l;
        r_ce_n = r.ce_n; r_rd_wr_n = r.rdwr_n; r_oe_n = r.oe_n; r_sem_n = r.sem_n;
        r_addr = r.a; r_din = r.d; r_busy_i = bi_r;
        #1;
        check(l_busy_o === eb_l, {tag, " l_busy_o"}, 32'(l_busy_o), 32'(eb_l));
        check(r_busy_o === eb_r, {tag, " r_busy_o"}, 32'(r_busy_o), 32'(eb_r));
        act_l = !l.ce_n && l.sem_n;
        act_r = !r.ce_n && r.sem_n;
        blk_l = ms_master ? eb_l : bi_l;
        blk_r = ms_master ? eb_r : bi_r;
        el.en   = act_l && l.rdwr_n && !l.oe_n;
        el.care = el.en && !blk_l;
        el.data = model[l.a];
        el.tag  = {tag, " left"};
        er.en   = act_r && r.rdwr_n && !r.oe_n;
        er.care = er.en && !blk_r;
        er.data = model[r.a];
        er.tag  = {tag, " right"};
        q_l.push_back(el);
        q_r.push_back(er);
        if (act_r && !r.rdwr_n && !blk_r) model[r.a] = r.d;
        if (act_l && !l.rdwr_n && !blk_l) model[l.a] = l.d;
    endtask

    task automatic compare(input exp_t e, input logic en, input logic [DW-1:0] d);
        check(en === e.en, {e.tag, " dout_en"}, 32'(en), 32'(e.en));
        if (e.care)
            check(d === e.data, {e.tag, " dout"}, 32'(d), 32'(e.data));
        else if (!e.en)
            check(d === '0, {e.tag, " dout idle R5"}, 32'(d), 32'(0));
    endtask

    // monitor: results appear one edge after their request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (q_l.size() > 0) compare(q_l.pop_front(), l_dout_en, l_dout);
                if (q_r.size() > 0) compare(q_r.pop_front(), r_dout_en, r_dout);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(0), 32'(1));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(l_dout_en === 1'b0 && r_dout_en === 1'b0, "reset dout_en", 
              32'({l_dout_en, r_dout_en}), 32'(0));
        check(l_busy_o === 1'b0 && r_busy_o === 1'b0, "reset busy",
              32'({l_busy_o, r_busy_o}), 32'(0));
        mon_on = 1;

        // R1 R3 R7: stores at both ends of the range in one cycle, then cross reads
        step(wr(0, 8'h11), wr(TOP, 8'hA5), 0, 0, 0, 0, "R1 R3 R7 dual store");
        step(rd(TOP), rd(0), 0, 0, 0, 0, "R1 R4 R7 cross read");
        step(wr(7, 8'h3C), wr(9, 8'hC3), 0, 0, 0, 0, "R7 dual store 2");
        step(rd(9), rd(7), 0, 0, 0, 0, "R4 R7 read 2");

        // R5: output enable high keeps pads off
        step('{0, 1, 1, 1, AW'(0), '0}, idle(), 0, 0, 0, 0, "R5 oe high");

        // R2: deselected store is ignored
        step(idle(), wr(5, 8'h33), 0, 0, 0, 0, "R2 seed");
        step('{1, 0, 1, 1, AW'(5), 8'h77}, idle(), 0, 0, 0, 0, "R2 deselected store");
        step('{1, 1, 0, 1, AW'(5), '0}, rd(5), 0, 0, 0, 0, "R2 deselected read");

        // R6: semaphore select low blocks memory access
        step('{0, 0, 1, 0, AW'(5), 8'h99}, idle(), 0, 0, 0, 0, "R6 sem store");
        step('{0, 1, 0, 0, AW'(5), '0}, rd(5), 0, 0, 0, 0, "R6 sem read");

        // R8 R10: fresh collision, left wins, right store dropped
        step(idle(), idle(), 0, 0, 0, 0, "gap");
        step(wr(10, 8'h10), wr(10, 8'h20), 0, 1, 0, 0, "R8 fresh collision");
        step(idle(), rd(10), 0, 0, 0, 0, "R10 read back");
        step(idle(), idle(), 0, 0, 0, 0, "gap");

        // R9 R10: right holds the address, left arrives
        step(wr(20, 8'h44), idle(), 0, 0, 0, 0, "R9 seed");
        step(idle(), idle(), 0, 0, 0, 0, "gap");
        step(idle(), rd(20), 0, 0, 0, 0, "R9 right owns");
        step(wr(20, 8'h55), rd(20), 1, 0, 0, 0, "R9 left newcomer");
        step(wr(20, 8'h56), rd(20), 1, 0, 0, 0, "R9 owner kept");
        step(wr(20, 8'h66), idle(), 0, 0, 0, 0, "R9 owner gone");
        step(idle(), rd(20), 0, 0, 0, 0, "R10 R9 read back");

        // R9: left holds, right arrives
        step(rd(30), idle(), 0, 0, 0, 0, "R9 left owns");
        step(rd(30), wr(30, 8'h77), 0, 1, 0, 0, "R9 right newcomer");
        step(idle(), rd(30), 0, 0, 0, 0, "R10 read 30");

        // R11: slave mode, busy comes from inputs
        ms_master = 1'b0;
        step(wr(41, 8'h12), idle(), 0, 0, 0, 0, "R11 seed");
        step(wr(40, 8'hAB), wr(41, 8'hEE), 0, 0, 1, 1, "R11 both held off");
        step(wr(40, 8'h5A), wr(40, 8'hCD), 0, 0, 1, 0, "R11 left held off");
        step(rd(40), rd(41), 0, 0, 0, 0, "R11 read back");
        step(idle(), idle(), 0, 0, 0, 0, "drain");
        step(idle(), idle(), 0, 0, 0, 0, "drain");
        repeat (2) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule